// File: doc/BRIEF.md
# Stereo DC Offset Remover with Hold

This block takes a stream of signed stereo samples that have already been decimated and removes the DC component from each channel. Every channel keeps its own running estimate of DC. On each valid sample the block subtracts that estimate from the sample, saturates the difference to the sample width and presents it on a registered output. In the same cycle the estimate moves a fixed fraction of the way toward the new sample. The corner frequency is therefore a fixed fraction of the sample rate.

A hold input stops the estimates from updating, but the held values are still subtracted from every sample. This supports a system offset calibration. First the block runs in tracking mode until the estimates have settled, which takes on the order of 10^5 samples at the default shift. Then hold is raised, and the offset of everything upstream stays cancelled while real signal passes through without being filtered.

The estimator is a first-order leaky integrator. Its accumulator is SHIFT_K bits wider than the samples.

Top module: `dc_offset_remover`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is 0 and both outputs are 0. Reset clears both estimates to 0, so the first sample after reset comes out unchanged.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, both outputs keep their previous values.
- R3: For each accepted sample x, the output is x minus the estimate that was held before this sample was taken, when that difference is in range.
- R4: Each channel has an accumulator A that is DATA_W+SHIFT_K bits wide. Its estimate is floor(A / 2^SHIFT_K), which is an arithmetic shift right by SHIFT_K. On an accepted sample with hold low, A becomes A + x - estimate.
- R5: On an accepted sample with `hold` high, A does not change. The held estimate is still subtracted.
- R6: The difference saturates to [-2^(DATA_W-1), 2^(DATA_W-1)-1] and does not wrap.
- R7: The left and right channels are fully independent. Each output depends only on its own input history.
- R8: A cycle with `in_valid` low leaves both estimates unchanged.
- R9: In tracking mode, a constant input drives the output of that channel to exactly 0 once the estimate has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| hold | input | 1 | 1 freezes both estimates; 0 lets them track |
| in_left | input | DATA_W | Left sample, two's complement |
| in_right | input | DATA_W | Right sample, two's complement |
| out_valid | output | 1 | Corrected sample present |
| out_left | output | DATA_W | Corrected left sample |
| out_right | output | DATA_W | Corrected right sample |

## Verification
The bench builds the block with DATA_W = 8 and SHIFT_K = 3. With these values it can sweep all 256 input codes on both channels, both while tracking and while held. Both saturation limits are reached with a held estimate of +100 or -77. A constant input settles to an output of exactly zero within a few hundred samples instead of about 10^5. The narrow accumulator lets an integer model in the bench follow the recurrence sample by sample across mixed tracking, idle, hold and reset sequences.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_LEFT  = 0;
  localparam int unsigned CH_RIGHT = 1;
endpackage

// File: rtl/dcr_estimator.sv
module dcr_estimator #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] est
);
  localparam int unsigned ACC_W = DATA_W + SHIFT_K;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic [ACC_W-1:0] x_ext;
  logic [ACC_W-1:0] e_ext;

  // Estimate is the accumulator floored by 2^SHIFT_K.
  assign est   = acc_q[ACC_W-1:SHIFT_K];
  assign x_ext = {{SHIFT_K{sample[DATA_W-1]}}, sample};
  assign e_ext = {{SHIFT_K{est[DATA_W-1]}}, est};
  // Stays in range: the accumulator is bounded by the sample range times 2^SHIFT_K.
  assign acc_next = acc_q + x_ext - e_ext;

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (upd) acc_q <= acc_next;
  end

  assert_idle_keeps_acc_R8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(acc_q));
endmodule

// File: rtl/dcr_saturate.sv
module dcr_saturate #(
  parameter int unsigned DATA_W = 24
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0] diff;

  assign diff = {a[DATA_W-1], a} - {b[DATA_W-1], b};

  always_comb begin
    if (diff[DATA_W] != diff[DATA_W-1]) y = diff[DATA_W] ? NEG_LIM : POS_LIM;
    else                                y = diff[DATA_W-1:0];
  end
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              hold,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] est;
  logic [DATA_W-1:0] diff_sat;
  logic [DATA_W-1:0] y_q;

  dcr_estimator #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K)) u_est (
    .clk    (clk),
    .rst    (rst),
    .upd    (in_valid & ~hold),
    .sample (sample),
    .est    (est)
  );

  dcr_saturate #(.DATA_W(DATA_W)) u_sat (
    .a (sample),
    .b (est),
    .y (diff_sat)
  );

  always_ff @(posedge clk) begin
    if (rst)           y_q <= '0;
    else if (in_valid) y_q <= diff_sat;
  end

  assign y = y_q;

  assert_hold_output_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(y_q));
  assert_frozen_est_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hold) |=> $stable(est));
  assert_no_wrap_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sample[DATA_W-1] && est[DATA_W-1]) |=> !y_q[DATA_W-1]);
  assert_no_wrap_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sample[DATA_W-1] && !est[DATA_W-1]) |=> y_q[DATA_W-1]);
endmodule

// File: rtl/dc_offset_remover.sv
module dc_offset_remover
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned SHIFT_K = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              hold,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  logic [DATA_W-1:0] smp [NUM_CH];
  logic [DATA_W-1:0] res [NUM_CH];
  logic              vld_q;

  assign smp[CH_LEFT]  = in_left;
  assign smp[CH_RIGHT] = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcr_channel #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .hold     (hold),
      .sample   (smp[c]),
      .y        (res[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
  end

  assign out_valid = vld_q;
  assign out_left  = res[CH_LEFT];
  assign out_right = res[CH_RIGHT];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_left == '0 && out_right == '0));
endmodule

// File: tb/dc_offset_remover_bench.sv
`timescale 1ns/1ps
module dc_offset_remover_bench;
  localparam int TW = 8;
  localparam int TK = 3;
  localparam longint LIM_P = (1 << (TW-1)) - 1;
  localparam longint LIM_N = -(1 << (TW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic hold = 1'b0;
  logic [TW-1:0] in_left = '0;
  logic [TW-1:0] in_right = '0;
  logic out_valid;
  logic [TW-1:0] out_left;
  logic [TW-1:0] out_right;

  int checks = 0;
  int errors = 0;
  longint acc_m [2];

  always #4 clk = ~clk;

  dc_offset_remover #(.DATA_W(TW), .SHIFT_K(TK)) u_dc_offset_remover (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hold(hold),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  function automatic longint clampv(longint v);
    if (v > LIM_P) return LIM_P;
    if (v < LIM_N) return LIM_N;
    return v;
  endfunction

  function automatic longint sv(logic [TW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Send one sample pair; expected values come from the R3/R4/R5/R6 arithmetic.
  task automatic send(longint l, longint r, bit frz, string req);
    longint el, er;
    el = clampv(l - (acc_m[0] >>> TK));
    er = clampv(r - (acc_m[1] >>> TK));
    if (!frz) begin
      acc_m[0] = acc_m[0] + l - (acc_m[0] >>> TK);
      acc_m[1] = acc_m[1] + r - (acc_m[1] >>> TK);
    end
    @(negedge clk);
    in_valid = 1'b1; hold = frz;
    in_left = TW'(l); in_right = TW'(r);
    @(negedge clk);
    in_valid = 1'b0; hold = 1'b0;
    chk(out_valid == 1'b1, {req, " R2 valid"}, out_valid, 1);
    chk(sv(out_left) == el, {req, " left"}, sv(out_left), el);
    chk(sv(out_right) == er, {req, " right"}, sv(out_right), er);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 in reset",
        sv(out_left), 0);
    rst = 1'b0;
    acc_m[0] = 0; acc_m[1] = 0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 after reset",
        sv(out_right), 0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [TW-1:0] keep_l, keep_r;
    acc_m[0] = 0; acc_m[1] = 0;
    do_reset();

    // R1 / R3: first sample after reset passes unchanged.
    send(37, -50, 1'b0, "R1 R3 first sample");

    // R3 R4 R6 R7: full tracking sweep, channels driven in opposite directions.
    for (int i = 0; i < 256; i++) send(i - 128, 127 - i, 1'b0, "R3 R4 R6 R7 sweep");

    // R2 R8: idle cycles keep outputs and estimates.
    keep_l = out_left; keep_r = out_right;
    repeat (5) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle valid", out_valid, 0);
      chk(out_left == keep_l && out_right == keep_r, "R2 idle hold",
          sv(out_left), sv(keep_l));
    end
    send(5, -5, 1'b0, "R8 estimate kept over idle");

    // R9: constant input settles to exactly zero.
    for (int i = 0; i < 300; i++) send(100, -77, 1'b0, "R4 R9 settle");
    chk(out_left == '0, "R9 left settled", sv(out_left), 0);
    chk(out_right == '0, "R9 right settled", sv(out_right), 0);

    // R5 R6: held estimates (+100 / -77) over every input code.
    for (int i = 0; i < 256; i++) begin
      send(i - 128, 127 - i, 1'b1, "R5 R6 held sweep");
      chk(sv(out_left) == clampv(i - 128 - 100), "R5 R6 left held", sv(out_left),
          clampv(i - 128 - 100));
      chk(sv(out_right) == clampv(127 - i + 77), "R5 R6 right held", sv(out_right),
          clampv(127 - i + 77));
    end
    send(100, -77, 1'b0, "R5 estimate unchanged after hold");
    chk(out_left == '0 && out_right == '0, "R5 zero after hold", sv(out_left), 0);

    // R1: reset mid-stream clears estimates.
    do_reset();
    send(-90, 64, 1'b0, "R1 pass after reset");
    chk(sv(out_left) == -90, "R1 left unchanged", sv(out_left), -90);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule